// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This unit carries out the sixteen integer data-processing operations of a 32-bit core datapath. Operands arrive fully formed: the first operand comes straight from the register file and the second has already passed through the shifter. The unit also receives the current carry flag for carry-chained arithmetic and the shifter's carry-out for logical operations.

It returns the result on the same cycle, together with a write enable for the destination register. The four condition flags (negative, zero, carry and overflow) are held in a register inside the unit. That register updates on the next rising clock edge when an update is called for.

Subtraction follows the carry-as-not-borrow convention. Carry set after a subtract means no borrow occurred. A carry-chained subtract takes away one extra unit when the incoming carry is clear.

The four test operations compute a value only to set the flags. They never request a register write.

Top module: `dp_alu`

## Requirements
- R1: With op_sel 4 (add) the result is a+b; with op_sel 5 (add with carry) it is a+b+carry_in, modulo 2^WIDTH.
- R2: With op_sel 2 (subtract) the result is a-b; with op_sel 6 (subtract with carry) it is a-b-(1-carry_in), modulo 2^WIDTH.
- R3: With op_sel 3 (reverse subtract) the result is b-a; with op_sel 7 (reverse subtract with carry) it is b-a-(1-carry_in).
- R4: Logical operations give a AND b for op_sel 0, a XOR b for op_sel 1, a OR b for op_sel 12, and a AND NOT b for op_sel 14.
- R5: With op_sel 13 the result is b; with op_sel 15 it is the bitwise inverse of b.
- R6: result_we is 0 for op_sel 8..11 (8 AND-test, 9 XOR-test, 10 compare as a-b, 11 compare-negative as a+b) and 1 for every other op_sel.
- R7: For op_sel 8..11 the flags update on the next rising edge whatever set_flags is. N takes the top bit of the computed value and Z is set when that value is zero.
- R8: For op_sel outside 8..11 the flags update only when set_flags is 1; otherwise all four flags keep their values.
- R9: On an arithmetic update (op_sel 2..7, 10, 11), C is the carry out of the unsigned addition. For subtracts this means C is 1 exactly when no borrow occurs. V is 1 exactly when the true signed result does not fit in WIDTH bits.
- R10: On a logical or move update (op_sel 0, 1, 8, 9, 12..15), C takes shift_carry and V keeps its previous value.
- R11: An active-low asynchronous reset clears all four flags to 0. The result and result_we follow the inputs within the same cycle, while the flags change only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, already shifted |
| op_sel | input | 4 | Operation select |
| set_flags | input | 1 | Request a flag update for non-test operations |
| carry_in | input | 1 | Carry flag used by carry-chained arithmetic |
| shift_carry | input | 1 | Shifter carry-out, loaded into C by logical operations |
| result | output | WIDTH | Combinational result |
| result_we | output | 1 | Destination register write enable |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The bench builds the unit at the default WIDTH of 32. At that width the signed limits 0x7FFFFFFF and 0x80000000 can be driven directly, so overflow in both directions can be exercised. All-ones operands bring wraparound to zero and the carry-out into reach. The bench's reference model works in 64-bit integers, so carry and overflow are judged against exact arithmetic rather than against a second adder.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_EOR  = 3'd1,
    LG_ORR  = 3'd2,
    LG_PASS = 3'd3,
    LG_BIC  = 3'd4,
    LG_NOT  = 3'd5
  } logic_sel_e;

  typedef struct packed {
    logic       arith;
    logic       swap;
    logic       inv_y;
    cin_sel_e   cin_sel;
    logic_sel_e lg_sel;
    logic       wr_en;
    logic       force_upd;
  } alu_ctrl_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_sel,
  output alu_ctrl_t  ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.cin_sel   = CIN_ZERO;
    ctrl.lg_sel    = LG_AND;
    ctrl.wr_en     = 1'b1;
    unique case (alu_op_e'(op_sel))
      OP_AND: ctrl.lg_sel = LG_AND;
      OP_EOR: ctrl.lg_sel = LG_EOR;
      OP_SUB: begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE;  end
      OP_RSB: begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.swap = 1'b1; ctrl.cin_sel = CIN_ONE; end
      OP_ADD: begin ctrl.arith = 1'b1; ctrl.cin_sel = CIN_ZERO; end
      OP_ADC: begin ctrl.arith = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      OP_SBC: begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      OP_RSC: begin ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.swap = 1'b1; ctrl.cin_sel = CIN_FLAG; end
      OP_TST: begin ctrl.lg_sel = LG_AND; ctrl.wr_en = 1'b0; ctrl.force_upd = 1'b1; end
      OP_TEQ: begin ctrl.lg_sel = LG_EOR; ctrl.wr_en = 1'b0; ctrl.force_upd = 1'b1; end
      OP_CMP: begin
        ctrl.arith = 1'b1; ctrl.inv_y = 1'b1; ctrl.cin_sel = CIN_ONE;
        ctrl.wr_en = 1'b0; ctrl.force_upd = 1'b1;
      end
      OP_CMN: begin
        ctrl.arith = 1'b1; ctrl.cin_sel = CIN_ZERO;
        ctrl.wr_en = 1'b0; ctrl.force_upd = 1'b1;
      end
      OP_ORR: ctrl.lg_sel = LG_ORR;
      OP_MOV: ctrl.lg_sel = LG_PASS;
      OP_BIC: ctrl.lg_sel = LG_BIC;
      OP_MVN: ctrl.lg_sel = LG_NOT;
      default: ctrl.lg_sel = LG_AND;
    endcase
  end

endmodule

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[WIDTH];
    ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
  end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic_sel_e       sel,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (sel)
      LG_AND:  y = a & b;
      LG_EOR:  y = a ^ b;
      LG_ORR:  y = a | b;
      LG_PASS: y = b;
      LG_BIC:  y = a & ~b;
      LG_NOT:  y = ~b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             arith,
  input  logic [WIDTH-1:0] value,
  input  logic             add_cout,
  input  logic             add_ovf,
  input  logic             shift_carry,
  output nzcv_t            flags_q
);

  localparam int MSB = WIDTH - 1;

  nzcv_t flags_d;

  always_comb begin
    flags_d   = flags_q;
    flags_d.n = value[MSB];
    flags_d.z = (value == '0);
    if (arith) begin
      flags_d.c = add_cout;
      flags_d.v = add_ovf;
    end else begin
      flags_d.c = shift_carry;
      flags_d.v = flags_q.v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (upd_en) begin
      flags_q <= flags_d;
    end
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_sel,
  input  logic             set_flags,
  input  logic             carry_in,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             result_we,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y_raw;
  logic [WIDTH-1:0] add_y;
  logic             add_cin;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] lg_out;
  nzcv_t            flags_q;

  dp_alu_decode u_dec (
    .op_sel (op_sel),
    .ctrl   (ctrl)
  );

  always_comb begin
    add_x     = ctrl.swap ? op_b : op_a;
    add_y_raw = ctrl.swap ? op_a : op_b;
    add_y     = ctrl.inv_y ? ~add_y_raw : add_y_raw;
    unique case (ctrl.cin_sel)
      CIN_ZERO: add_cin = 1'b0;
      CIN_ONE:  add_cin = 1'b1;
      CIN_FLAG: add_cin = carry_in;
      default:  add_cin = 1'b0;
    endcase
  end

  dp_alu_addsub #(.WIDTH(WIDTH)) u_add (
    .x    (add_x),
    .y    (add_y),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_lg (
    .a   (op_a),
    .b   (op_b),
    .sel (ctrl.lg_sel),
    .y   (lg_out)
  );

  assign result    = ctrl.arith ? add_sum : lg_out;
  assign result_we = ctrl.wr_en;

  dp_alu_flags #(.WIDTH(WIDTH)) u_flg (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_en      (set_flags | ctrl.force_upd),
    .arith       (ctrl.arith),
    .value       (result),
    .add_cout    (add_cout),
    .add_ovf     (add_ovf),
    .shift_carry (shift_carry),
    .flags_q     (flags_q)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_sel,
  input logic             set_flags,
  input logic             shift_carry,
  input logic [WIDTH-1:0] result,
  input logic             result_we,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_c,
  input logic             flag_v
);

  logic is_test;
  logic is_logic;
  logic upd;

  assign is_test  = (op_sel[3:2] == 2'b10);
  assign is_logic = (op_sel[3:2] == 2'b11) || (op_sel[3:1] == 3'b000) ||
                    (op_sel[3:1] == 3'b100);
  assign upd      = set_flags || is_test;

  p_test_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_test |-> !result_we);

  p_other_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_test |-> result_we);

  p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable({flag_n, flag_z, flag_c, flag_v}));

  p_z_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flag_z == ($past(result) == '0)));

  p_n_tracks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flag_n == $past(result[WIDTH-1])));

  p_logic_keeps_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_logic) |=> $stable(flag_v));

  p_logic_c_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_logic) |=> (flag_c == $past(shift_carry)));

endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_sel      (op_sel),
  .set_flags   (set_flags),
  .shift_carry (shift_carry),
  .result      (result),
  .result_we   (result_we),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .flag_v      (flag_v)
);

// File: tb/dp_alu_test.sv
module dp_alu_test;

  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         chk_res;
    logic         we;
    logic [3:0]   nzcv;
    string        tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [3:0]   op_sel;
  logic         set_flags;
  logic         carry_in;
  logic         shift_carry;
  logic [W-1:0] result;
  logic         result_we;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks   = 0;
  int failures = 0;
  exp_t sb[$];
  logic [3:0] m_flags;

  dp_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .set_flags(set_flags), .carry_in(carry_in), .shift_carry(shift_carry),
    .result(result), .result_we(result_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Exact-integer reference; kind 0: p+q+k, kind 1: p-q-(1-k)
  task automatic model_arith(input int kind, input logic [W-1:0] p,
                             input logic [W-1:0] q, input logic k,
                             output logic [W-1:0] r, output logic c,
                             output logic v);
    longint up, uq, sp, sq, ur, sr;
    up = longint'({32'd0, p});
    uq = longint'({32'd0, q});
    sp = $signed(p);
    sq = $signed(q);
    if (kind == 0) begin
      ur = up + uq + longint'(k);
      sr = sp + sq + longint'(k);
      c  = (ur >= 64'sh1_0000_0000);
    end else begin
      ur = up - uq - longint'(!k);
      sr = sp - sq - longint'(!k);
      c  = (ur >= 0);
    end
    r = ur[W-1:0];
    v = (sr > 64'sh7FFF_FFFF) || (sr < -64'sh8000_0000);
  endtask

  task automatic drive(input logic [3:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci, input logic sc,
                       input logic sf, input string tag);
    exp_t e;
    logic [W-1:0] r;
    logic c, v, arith, test;
    c = 1'b0; v = 1'b0; r = '0; arith = 1'b1;
    case (op)
      4'd4:  model_arith(0, a, b, 1'b0, r, c, v);
      4'd5:  model_arith(0, a, b, ci, r, c, v);
      4'd11: model_arith(0, a, b, 1'b0, r, c, v);
      4'd2:  model_arith(1, a, b, 1'b1, r, c, v);
      4'd10: model_arith(1, a, b, 1'b1, r, c, v);
      4'd6:  model_arith(1, a, b, ci, r, c, v);
      4'd3:  model_arith(1, b, a, 1'b1, r, c, v);
      4'd7:  model_arith(1, b, a, ci, r, c, v);
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8:  r = a & b;
          4'd1, 4'd9:  r = a ^ b;
          4'd12:       r = a | b;
          4'd13:       r = b;
          4'd14:       r = a & ~b;
          default:     r = ~b;
        endcase
      end
    endcase
    test = (op >= 4'd8) && (op <= 4'd11);
    if (sf || test) begin
      m_flags[3] = r[W-1];
      m_flags[2] = (r == '0);
      m_flags[1] = arith ? c : sc;
      m_flags[0] = arith ? v : m_flags[0];
    end
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; carry_in = ci;
    shift_carry = sc; set_flags = sf;
    e.res = r; e.chk_res = !test; e.we = !test; e.nzcv = m_flags; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: result is combinational and still held; flags just updated
  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      logic bad;
      e = sb.pop_front();
      bad = (result_we !== e.we) ||
            ({flag_n, flag_z, flag_c, flag_v} !== e.nzcv) ||
            (e.chk_res && (result !== e.res));
      checks++;
      if (bad) begin
        failures++;
        $display("FAIL %s: res=%h we=%b nzcv=%b expected res=%h we=%b nzcv=%b",
                 e.tag, result, result_we, {flag_n, flag_z, flag_c, flag_v},
                 e.res, e.we, e.nzcv);
      end
    end
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_flags = 4'b0000;
    rst_n = 1'b0; op_a = '0; op_b = '0; op_sel = 4'd13;
    set_flags = 1'b1; carry_in = 1'b1; shift_carry = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    checks++;   // R11 reset clears flags
    if ({flag_n, flag_z, flag_c, flag_v} !== 4'b0000) begin
      failures++;
      $display("FAIL R11: nzcv=%b expected 0000",
               {flag_n, flag_z, flag_c, flag_v});
    end
    set_flags = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    drive(4'd4, 32'd5, 32'd7, 1'b0, 1'b0, 1'b1, "R1");
    drive(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, "R9");
    drive(4'd4, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, "R9");
    drive(4'd5, 32'd10, 32'd20, 1'b1, 1'b0, 1'b1, "R1");
    drive(4'd5, 32'hFFFF_FFFF, 32'd0, 1'b1, 1'b0, 1'b1, "R1");
    drive(4'd2, 32'd5, 32'd7, 1'b0, 1'b0, 1'b1, "R2");
    drive(4'd2, 32'd7, 32'd7, 1'b0, 1'b0, 1'b1, "R2");
    drive(4'd2, 32'h8000_0000, 32'd1, 1'b0, 1'b0, 1'b1, "R9");
    drive(4'd6, 32'd10, 32'd3, 1'b0, 1'b0, 1'b1, "R2");
    drive(4'd6, 32'd10, 32'd3, 1'b1, 1'b0, 1'b1, "R2");
    drive(4'd3, 32'd3, 32'd10, 1'b0, 1'b0, 1'b1, "R3");
    drive(4'd3, 32'd10, 32'd3, 1'b0, 1'b0, 1'b1, "R3");
    drive(4'd7, 32'd3, 32'd10, 1'b0, 1'b0, 1'b1, "R3");
    drive(4'd7, 32'd0, 32'd0, 1'b0, 1'b0, 1'b1, "R3");
    drive(4'd4, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b1, "R9");
    drive(4'd0, 32'hF0F0_1234, 32'h0FF0_FFFF, 1'b0, 1'b1, 1'b1, "R10");
    drive(4'd1, 32'hAAAA_5555, 32'hAAAA_5555, 1'b0, 1'b0, 1'b1, "R4");
    drive(4'd12, 32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 1'b1, "R4");
    drive(4'd14, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b0, 1'b0, 1'b1, "R4");
    drive(4'd13, 32'h1234_5678, 32'h8765_4321, 1'b0, 1'b1, 1'b1, "R5");
    drive(4'd15, 32'h0, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R5");
    drive(4'd4, 32'h7FFF_FFFF, 32'd5, 1'b0, 1'b0, 1'b0, "R8");
    drive(4'd14, 32'd0, 32'd0, 1'b0, 1'b1, 1'b0, "R8");
    drive(4'd10, 32'd3, 32'd3, 1'b0, 1'b0, 1'b0, "R7");
    drive(4'd11, 32'h7FFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, "R6");
    drive(4'd8, 32'hF000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, "R7");
    drive(4'd9, 32'h55, 32'h55, 1'b0, 1'b1, 1'b0, "R6");
    drive(4'd10, 32'd1, 32'd2, 1'b1, 1'b0, 1'b1, "R11");
    drive(4'd5, 32'd1, 32'd1, 1'b0, 1'b0, 1'b0, "R8");

    repeat (4) @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule